// File: doc/BRIEF.md
# Digital PLL Operating-Mode Controller

This block decides which source steers the digitally controlled oscillator of a digital PLL. While a qualified reference is present the loop is closed and the loop-filter word passes straight to the oscillator. When the reference disappears, the loop opens and the oscillator runs on its own. It runs either from a stored estimate of the frequency it had while locked (holdover) or from a nominal zero-offset word (freerun).

The stored estimate is a running average of the loop-filter word. It is only taken once the loop has been locked long enough to settle. The block tracks how long the loop has been in holdover. When the estimate is missing or has grown too old, the block uses freerun instead of holdover.

On the way back into lock, the block freezes the loop integrator and then preloads it with the word that is driving the oscillator at that moment. This keeps the output frequency from jumping at the switch-over.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset the mode output is 2'b00 (freerun), the oscillator word is 0, the freeze output is high and the load output is low. The mode encoding is 2'b00 freerun, 2'b01 locked and 2'b10 holdover; 2'b11 never appears.
- R2: The reference counts as qualified once `ref_ok` has been high at QUAL_CNT consecutive clock edges and is still high. Any low cycle restarts the count, so a shorter run never leads to locked mode.
- R3: In locked mode the oscillator word equals the loop-filter input in the same cycle.
- R4: If `ref_ok` is low during a locked cycle, the next mode is holdover when the history is valid and freerun otherwise.
- R5: History is sampled at every edge with locked mode and `ref_ok` high. The HIST_MIN-th consecutive such sample seeds the average with the input word and marks the history valid. Each later sample sets avg = avg + floor((word - avg) / 2^AVG_SHIFT).
- R6: In holdover the oscillator word is the stored average, and changes on the loop-filter input have no effect on it.
- R7: Holdover lasts at most MAX_AGE clock cycles. The block then moves to freerun and the history becomes invalid, so a later loss of lock with fewer than HIST_MIN samples goes to freerun.
- R8: In freerun the oscillator word is 0.
- R9: When the reference qualifies outside locked mode, `integ_load` is high for exactly one cycle and `integ_load_word` carries the oscillator word of that cycle. Locked mode starts at the next edge.
- R10: `integ_freeze` is high in every mode except locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Reference judged valid this cycle |
| lf_word | input | CW_W | Signed loop-filter control word |
| integ_freeze | output | 1 | Hold the loop integrator |
| integ_load | output | 1 | One-cycle preload strobe for the integrator |
| integ_load_word | output | CW_W | Value to preload into the integrator |
| osc_word | output | CW_W | Signed control word to the oscillator |
| mode | output | 2 | Current mode (00 freerun, 01 locked, 10 holdover) |

## Verification
A wrong mode register shows on `osc_word` and `integ_freeze` in the same cycle, because both decode the mode without any further register. A wrong history average stays hidden until the reference drops. It then appears on `osc_word` in the first holdover cycle, and again as the preload word when lock returns. A wrong age or qualification count appears as a mode change one edge early or one edge late. The bench therefore compares the mode at the exact expected edge on both sides of each boundary.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_HOLD = 2'b10
  } pll_mode_e;
endpackage

// File: rtl/pll_ref_qual.sv
module pll_ref_qual #(
  parameter int QUAL_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok,
  output logic qual_ok
);
  localparam int QW = $clog2(QUAL_CNT + 1);

  logic [QW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          run_cnt <= '0;
    else if (!ref_ok)                    run_cnt <= '0;
    else if (run_cnt != QW'(QUAL_CNT))   run_cnt <= run_cnt + 1'b1;
  end

  assign qual_ok = ref_ok && (run_cnt == QW'(QUAL_CNT));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= QW'(QUAL_CNT));
  // R2
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> (run_cnt <= QW'(1)));
endmodule

// File: rtl/pll_hist_mem.sv
module pll_hist_mem #(
  parameter int CW_W      = 24,
  parameter int AVG_SHIFT = 4,
  parameter int HIST_MIN  = 16,
  parameter int MAX_AGE   = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_en,
  input  logic                   in_hold,
  input  logic signed [CW_W-1:0] lf_word,
  output logic signed [CW_W-1:0] hist_word,
  output logic                   hist_valid,
  output logic                   stale
);
  localparam int LW = $clog2(HIST_MIN + 1);
  localparam int AW = $clog2(MAX_AGE);

  function automatic logic signed [CW_W-1:0] avg_step(
    input logic signed [CW_W-1:0] cur,
    input logic signed [CW_W-1:0] smp
  );
    logic signed [CW_W:0] diff;
    diff = {smp[CW_W-1], smp} - {cur[CW_W-1], cur};
    diff = diff >>> AVG_SHIFT;
    return cur + signed'(diff[CW_W-1:0]);
  endfunction

  logic [LW-1:0] lock_cnt;
  logic [AW-1:0] age_cnt;
  logic          settled;
  logic          seed_now;

  assign settled  = (lock_cnt == LW'(HIST_MIN));
  assign seed_now = sample_en && (lock_cnt == LW'(HIST_MIN - 1));
  assign stale    = in_hold && (age_cnt == AW'(MAX_AGE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          lock_cnt <= '0;
    else if (!sample_en) lock_cnt <= '0;
    else if (!settled)   lock_cnt <= lock_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     hist_word <= '0;
    else if (seed_now)              hist_word <= lf_word;
    else if (sample_en && settled)  hist_word <= avg_step(hist_word, lf_word);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_valid <= 1'b0;
    else if (stale)    hist_valid <= 1'b0;
    else if (seed_now) hist_valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        age_cnt <= '0;
    else if (!in_hold) age_cnt <= '0;
    else if (!stale)   age_cnt <= age_cnt + 1'b1;
  end

  // R6
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && $past(in_hold)) |-> $stable(hist_word));
  // R7
  age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_cnt < AW'(MAX_AGE));
  // R7
  stale_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale |=> !hist_valid);
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_ok,
  input  logic      qual_ok,
  input  logic      hist_valid,
  input  logic      stale,
  output pll_mode_e mode,
  output logic      enter_lock
);
  pll_mode_e nxt;

  always_comb begin
    nxt = mode;
    unique case (mode)
      MODE_FREE: if (qual_ok) nxt = MODE_LOCK;
      MODE_HOLD: begin
        if (qual_ok)    nxt = MODE_LOCK;
        else if (stale) nxt = MODE_FREE;
      end
      MODE_LOCK: if (!ref_ok) nxt = hist_valid ? MODE_HOLD : MODE_FREE;
      default:   nxt = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_FREE;
    else        mode <= nxt;
  end

  assign enter_lock = (mode != MODE_LOCK) && qual_ok;

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  // R2
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOCK && $past(mode) != MODE_LOCK) |-> $past(qual_ok));
  // R4
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && $past(mode) == MODE_LOCK) |-> $past(hist_valid));
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int CW_W      = 24,
  parameter int AVG_SHIFT = 4,
  parameter int HIST_MIN  = 16,
  parameter int MAX_AGE   = 1000,
  parameter int QUAL_CNT  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_ok,
  input  logic signed [CW_W-1:0] lf_word,
  output logic                   integ_freeze,
  output logic                   integ_load,
  output logic signed [CW_W-1:0] integ_load_word,
  output logic signed [CW_W-1:0] osc_word,
  output logic [1:0]             mode
);
  pll_mode_e             cur_mode;
  logic                  qual_ok;
  logic                  enter_lock;
  logic                  hist_valid;
  logic                  stale;
  logic                  sample_en;
  logic                  in_hold;
  logic signed [CW_W-1:0] hist_word;

  pll_ref_qual #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .qual_ok(qual_ok)
  );

  assign sample_en = (cur_mode == MODE_LOCK) && ref_ok;
  assign in_hold   = (cur_mode == MODE_HOLD);

  pll_hist_mem #(
    .CW_W(CW_W), .AVG_SHIFT(AVG_SHIFT), .HIST_MIN(HIST_MIN), .MAX_AGE(MAX_AGE)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .in_hold(in_hold),
    .lf_word(lf_word), .hist_word(hist_word), .hist_valid(hist_valid),
    .stale(stale)
  );

  pll_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .qual_ok(qual_ok),
    .hist_valid(hist_valid), .stale(stale), .mode(cur_mode),
    .enter_lock(enter_lock)
  );

  always_comb begin
    unique case (cur_mode)
      MODE_LOCK: osc_word = lf_word;
      MODE_HOLD: osc_word = hist_word;
      default:   osc_word = '0;
    endcase
  end

  assign integ_freeze    = (cur_mode != MODE_LOCK);
  assign integ_load      = enter_lock;
  assign integ_load_word = osc_word;
  assign mode            = cur_mode;

  // R9
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_load |=> !integ_load);
  // R9
  load_then_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_load |=> (mode == 2'b01));
endmodule

// File: tb/pll_mode_ctrl_tb.sv
module pll_mode_ctrl_tb;
  localparam int W   = 16;
  localparam int SH  = 2;
  localparam int HM  = 4;
  localparam int AGE = 20;
  localparam int QC  = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                ref_ok = 1'b0;
  logic signed [W-1:0] lf_word = '0;
  logic                integ_freeze;
  logic                integ_load;
  logic signed [W-1:0] integ_load_word;
  logic signed [W-1:0] osc_word;
  logic [1:0]          mode;

  int checks = 0;
  int errors = 0;
  int m_avg = 0;
  bit m_valid = 1'b0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  pll_mode_ctrl #(
    .CW_W(W), .AVG_SHIFT(SH), .HIST_MIN(HM), .MAX_AGE(AGE), .QUAL_CNT(QC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lf_word(lf_word),
    .integ_freeze(integ_freeze), .integ_load(integ_load),
    .integ_load_word(integ_load_word), .osc_word(osc_word), .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst_n = 1'b1;
    chk("R1 mode", mode, 0);
    chk("R1 osc", osc_word, 0);
    chk("R1 freeze", integ_freeze, 1);
    chk("R1 load", integ_load, 0);
    tick();
    chk("R8 freerun word", osc_word, 0);
  endtask

  task automatic t_gap();
    ref_ok = 1'b1;
    tick(); tick();
    ref_ok = 1'b0;
    chk("R2 no load on short run", integ_load, 0);
    tick();
    chk("R2 still freerun after gap", mode, 0);
  endtask

  task automatic qualify(input int prior, input int exp_word);
    ref_ok = 1'b1;
    tick(); tick();
    chk("R2 not yet qualified", integ_load, 0);
    chk("R2 mode held", mode, prior);
    tick();
    chk("R9 load strobe", integ_load, 1);
    chk("R9 load word", integ_load_word, exp_word);
    chk("R10 freeze before lock", integ_freeze, 1);
    tick();
    chk("R2 locked", mode, 1);
    chk("R9 strobe one cycle", integ_load, 0);
    chk("R10 freeze released", integ_freeze, 0);
    m_cnt = 0;
  endtask

  task automatic run_lock(input int n, input int base, input int stp);
    for (int i = 0; i < n; i++) begin
      lf_word = W'(base + i * stp);
      #1;
      chk("R3 passthrough", osc_word, base + i * stp);
      tick();
      m_cnt++;
      if (m_cnt == HM) begin
        m_avg = base + i * stp;
        m_valid = 1'b1;
      end else if (m_cnt > HM) begin
        m_avg = m_avg + ((base + i * stp - m_avg) >>> SH);
      end
    end
  endtask

  task automatic drop();
    ref_ok = 1'b0;
    tick();
    chk("R4 mode after loss", mode, m_valid ? 2 : 0);
    chk("R5 held word", osc_word, m_valid ? m_avg : 0);
  endtask

  task automatic t_hold_ignores();
    lf_word = 16'sd5000;
    tick(); tick();
    chk("R6 word ignores input", osc_word, m_avg);
    chk("R10 freeze in holdover", integ_freeze, 1);
    chk("R6 mode holdover", mode, 2);
  endtask

  task automatic t_age();
    repeat (AGE - 1) tick();
    chk("R7 still holdover at limit", mode, 2);
    tick();
    chk("R7 freerun after age", mode, 0);
    chk("R8 zero word", osc_word, 0);
    m_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gap();
    qualify(0, 0);
    run_lock(2, 40, 1);
    drop();
    qualify(0, 0);
    run_lock(10, 100, 8);
    drop();
    t_hold_ignores();
    qualify(2, m_avg);
    run_lock(6, -300, -5);
    drop();
    t_age();
    qualify(0, 0);
    run_lock(2, 7, 3);
    drop();
    chk("R7 history invalid", mode, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule